// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds or subtracts two 64-bit packed operands lane by lane and returns the packed result one clock later. The lane width is chosen per operation as 8, 16 or 32 bits. Each lane is computed on its own: no carry or borrow passes from one lane into the next. The destination operand `dst_in` is the left operand. Its register in the surrounding datapath is meant to be overwritten with `res_out`. Subtraction computes `dst_in - src_in`.

Three arithmetic behaviours are offered. Wraparound keeps only the low bits of each lane. Signed clamping pins an out-of-range lane to the most negative or most positive two's-complement value. Unsigned clamping pins it to zero or to all ones. Clamping exists for 8- and 16-bit lanes only; 32-bit lanes always wrap. The block produces no carry, overflow or other condition outputs.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_out` becomes zero and `res_valid` becomes low at that edge.
- R2: `res_valid` is high exactly in the cycle after a cycle with `valid_in` high and `rst` low. `res_out` keeps its value after any edge at which `valid_in` was low.
- R3: With `arith_md` = 0 (wraparound), each lane of `res_out` equals the low lane-width bits of the lane sum (`op_sub` = 0) or of `dst_in` lane minus `src_in` lane (`op_sub` = 1). No carry or borrow crosses a lane boundary.
- R4: With `lane_sz` = 0 (8-bit lanes) and `arith_md` = 1 (signed clamp), a lane result below -128 gives 0x80 and a result above 127 gives 0x7F. In-range results are exact.
- R5: With `lane_sz` = 1 (16-bit lanes) and `arith_md` = 1, a lane result below -32768 gives 0x8000 and a result above 32767 gives 0x7FFF. In-range results are exact.
- R6: With `lane_sz` = 0 and `arith_md` = 2 (unsigned clamp), a lane sum above 255 gives 0xFF and a negative difference gives 0x00.
- R7: With `lane_sz` = 1 and `arith_md` = 2, a lane sum above 65535 gives 0xFFFF and a negative difference gives 0x0000.
- R8: With `lane_sz` = 2 (32-bit lanes), every `arith_md` value gives the wraparound result.
- R9: The spare codes act as follows: `lane_sz` = 3 behaves as 32-bit lanes, and `arith_md` = 3 behaves as wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (dst minus src) |
| lane_sz | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit lanes |
| arith_md | input | 2 | 0 or 3 = wraparound, 1 = signed clamp, 2 = unsigned clamp |
| dst_in | input | 64 | Destination (left) operand |
| src_in | input | 64 | Source (right) operand |
| res_out | output | 64 | Registered packed result |
| res_valid | output | 1 | Result registered from a valid input |

## Verification
Two lanes in the same word can need different handling in the same cycle. One lane can clamp while the lane beside it wraps or carries out at exactly its top bit. A stray carry or a clamp decision read from the wrong slice would then corrupt only the neighbour. The bench provokes this with operands that mix 0xFF, 0x7F and 0x80 patterns in adjacent lanes at all three lane widths, plus a long run of random vectors. Every clock it compares the whole result against a lane-by-lane integer model that extends, adds and clamps each lane on its own.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;
  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_SPARE = 2'd3
  } lane_sz_t;

  typedef enum logic [1:0] {
    MD_WRAP  = 2'd0,
    MD_SSAT  = 2'd1,
    MD_USAT  = 2'd2,
    MD_SPARE = 2'd3
  } arith_md_t;
endpackage

// File: rtl/simd_byte_slice.sv
`timescale 1ns/1ps
// One slice of the carry chain: adds dst and (optionally inverted) src.
// Brings out the carry into the top bit and the carry out for overflow decisions.
module simd_byte_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_top,
  output logic         c_out
);
  logic [W-1:0] b_eff;
  logic [W-1:0] low;
  logic         s_msb;

  assign b_eff = sub ? ~b : b;
  assign low   = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign c_top = low[W-1];
  assign {c_out, s_msb} = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_top};
  assign sum   = {s_msb, low[W-2:0]};
endmodule

// File: rtl/simd_lane_clamp.sv
`timescale 1ns/1ps
// Per-slice result select: each slice reads the overflow flags of its lane's top slice.
module simd_lane_clamp #(
  parameter int N_SL = 8,
  parameter int SW   = 8
) (
  input  logic [1:0]         lane_sz,
  input  logic [1:0]         arith_md,
  input  logic               op_sub,
  input  logic [SW-1:0]      sums [N_SL],
  input  logic               ctop [N_SL],
  input  logic               cout [N_SL],
  input  logic               amsb [N_SL],
  output logic [N_SL*SW-1:0] res
);
  localparam int IDX_W = (N_SL > 1) ? $clog2(N_SL) : 1;

  logic narrow;
  assign narrow = ~lane_sz[1];

  for (genvar i = 0; i < N_SL; i++) begin : g_cl
    localparam logic [IDX_W-1:0] TOP_B = IDX_W'(i);
    localparam logic [IDX_W-1:0] TOP_W = IDX_W'(i | 1);
    localparam logic [IDX_W-1:0] TOP_D = IDX_W'(i | 3);

    logic [IDX_W-1:0] top;
    logic             sat_s;
    logic             sat_u;

    always_comb begin
      case (lane_sz)
        2'd0:    top = TOP_B;
        2'd1:    top = TOP_W;
        default: top = TOP_D;
      endcase
    end

    assign sat_s = narrow && (arith_md == 2'd1) && (ctop[top] ^ cout[top]);
    assign sat_u = narrow && (arith_md == 2'd2) && (cout[top] ^ op_sub);

    always_comb begin
      if (sat_s) begin
        if (top == TOP_B) res[i*SW +: SW] = {amsb[top], {(SW-1){~amsb[top]}}};
        else              res[i*SW +: SW] = {SW{~amsb[top]}};
      end else if (sat_u) begin
        res[i*SW +: SW] = {SW{~op_sub}};
      end else begin
        res[i*SW +: SW] = sums[i];
      end
    end
  end
endmodule

// File: rtl/simd_out_reg.sv
`timescale 1ns/1ps
module simd_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
`timescale 1ns/1ps
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic              op_sub,
  input  logic [1:0]        lane_sz,
  input  logic [1:0]        arith_md,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  output logic [DATA_W-1:0] res_out,
  output logic              res_valid
);
  localparam int N_SL = DATA_W / SLICE_W;

  logic [SLICE_W-1:0] sl_sum  [N_SL];
  logic               sl_ctop [N_SL];
  logic               sl_cout [N_SL];
  logic               sl_amsb [N_SL];
  logic [DATA_W-1:0]  lane_res;

  for (genvar i = 0; i < N_SL; i++) begin : g_sl
    logic cin;
    logic cout_w;

    if (i == 0) begin : g_first
      assign cin = op_sub;
    end else begin : g_rest
      logic lane_start;
      always_comb begin
        case (lane_sz)
          2'd0:    lane_start = 1'b1;
          2'd1:    lane_start = ((i % 2) == 0);
          default: lane_start = ((i % 4) == 0);
        endcase
      end
      assign cin = lane_start ? op_sub : g_sl[i-1].cout_w;
    end

    simd_byte_slice #(.W(SLICE_W)) u_slice (
      .a     (dst_in[i*SLICE_W +: SLICE_W]),
      .b     (src_in[i*SLICE_W +: SLICE_W]),
      .sub   (op_sub),
      .cin   (cin),
      .sum   (sl_sum[i]),
      .c_top (sl_ctop[i]),
      .c_out (cout_w)
    );

    assign sl_cout[i] = cout_w;
    assign sl_amsb[i] = dst_in[i*SLICE_W + SLICE_W - 1];
  end

  simd_lane_clamp #(.N_SL(N_SL), .SW(SLICE_W)) u_clamp (
    .lane_sz  (lane_sz),
    .arith_md (arith_md),
    .op_sub   (op_sub),
    .sums     (sl_sum),
    .ctop     (sl_ctop),
    .cout     (sl_cout),
    .amsb     (sl_amsb),
    .res      (lane_res)
  );

  simd_out_reg #(.W(DATA_W)) u_oreg (
    .clk (clk),
    .rst (rst),
    .en  (valid_in),
    .d   (lane_res),
    .q   (res_out),
    .vld (res_valid)
  );
endmodule

// File: rtl/simd_sat_adder_chk.sv
`timescale 1ns/1ps
module simd_sat_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_in,
  input logic              op_sub,
  input logic [1:0]        lane_sz,
  input logic [1:0]        arith_md,
  input logic [DATA_W-1:0] dst_in,
  input logic [DATA_W-1:0] src_in,
  input logic [DATA_W-1:0] res_out,
  input logic              res_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (res_out == '0 && !res_valid));

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(valid_in && !rst));

  // R2
  hold_res_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!valid_in && !rst) |-> $stable(res_out));

  for (genvar i = 0; i < DATA_W / 8; i++) begin : g_byte
    // R3
    wrap_byte_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && !op_sub && lane_sz == 2'd0 && arith_md == 2'd0)
      |-> res_out[i*8 +: 8] == $past(dst_in[i*8 +: 8] + src_in[i*8 +: 8]));

    // R6
    usat_add_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && !op_sub && lane_sz == 2'd0 && arith_md == 2'd2)
      |-> (res_out[i*8 +: 8] >= $past(dst_in[i*8 +: 8]) &&
           res_out[i*8 +: 8] >= $past(src_in[i*8 +: 8])));

    // R6
    usat_sub_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && op_sub && lane_sz == 2'd0 && arith_md == 2'd2)
      |-> res_out[i*8 +: 8] <= $past(dst_in[i*8 +: 8]));
  end

  for (genvar j = 0; j < DATA_W / 32; j++) begin : g_dw
    // R8
    dword_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      $past(valid_in && !rst && !op_sub && lane_sz == 2'd2)
      |-> res_out[j*32 +: 32] == $past(dst_in[j*32 +: 32] + src_in[j*32 +: 32]));
  end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .op_sub    (op_sub),
  .lane_sz   (lane_sz),
  .arith_md  (arith_md),
  .dst_in    (dst_in),
  .src_in    (src_in),
  .res_out   (res_out),
  .res_valid (res_valid)
);

// File: tb/simd_sat_adder_test.sv
`timescale 1ns/1ps
module simd_sat_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic        op_sub = 1'b0;
  logic [1:0]  lane_sz = 2'd0;
  logic [1:0]  arith_md = 2'd0;
  logic [63:0] dst_in = '0;
  logic [63:0] src_in = '0;
  logic [63:0] res_out;
  logic        res_valid;

  int          checks = 0;
  int          errors = 0;
  logic [63:0] exp_res = '0;
  logic        exp_vld = 1'b0;

  always #4 clk = ~clk;

  simd_sat_adder uut (
    .clk (clk), .rst (rst), .valid_in (valid_in), .op_sub (op_sub),
    .lane_sz (lane_sz), .arith_md (arith_md), .dst_in (dst_in),
    .src_in (src_in), .res_out (res_out), .res_valid (res_valid)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic sub, logic [1:0] sz, logic [1:0] md);
    int w;
    int m;
    logic [63:0] r;
    w = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
    m = int'(md);
    if (w == 32 || m == 3) m = 0;
    r = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint mask;
      longint x;
      longint y;
      longint t;
      mask = (longint'(1) <<< w) - 1;
      x = longint'(a >> (k * w)) & mask;
      y = longint'(b >> (k * w)) & mask;
      if (m == 1) begin
        if (x >= (longint'(1) <<< (w - 1))) x = x - (longint'(1) <<< w);
        if (y >= (longint'(1) <<< (w - 1))) y = y - (longint'(1) <<< w);
      end
      t = sub ? x - y : x + y;
      if (m == 1) begin
        if (t < -(longint'(1) <<< (w - 1))) t = -(longint'(1) <<< (w - 1));
        if (t > (longint'(1) <<< (w - 1)) - 1) t = (longint'(1) <<< (w - 1)) - 1;
      end else if (m == 2) begin
        if (t < 0) t = 0;
        if (t > mask) t = mask;
      end
      r = r | (64'(t & mask) << (k * w));
    end
    return r;
  endfunction

  task automatic step(input logic r, input logic v, input logic s,
                      input logic [1:0] sz, input logic [1:0] md,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    rst = r; valid_in = v; op_sub = s; lane_sz = sz; arith_md = md;
    dst_in = a; src_in = b;
    if (r) begin
      exp_res = '0; exp_vld = 1'b0;
    end else begin
      exp_vld = v;
      if (v) exp_res = model(a, b, s, sz, md);
    end
    @(negedge clk);
    checks++;
    if (res_out !== exp_res) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", tag, res_out, exp_res);
    end
    checks++;
    if (res_valid !== exp_vld) begin
      errors++;
      $display("FAIL %s valid actual=%b expected=%b", tag, res_valid, exp_vld);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, also with valid asserted during reset
    step(1, 1, 0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R1");
    step(1, 0, 0, 2'd0, 2'd0, '0, '0, "R1");
    // R3: wraparound with carries at every lane edge
    step(0, 1, 0, 2'd0, 2'd0, 64'hFF01_FF80_FFFF_00FF, 64'h01FF_0180_0101_0001, "R3");
    step(0, 1, 1, 2'd0, 2'd0, 64'h0001_0000_8000_0100, 64'h0102_0001_0001_0001, "R3");
    step(0, 1, 0, 2'd1, 2'd0, 64'hFFFF_0001_8000_FFFF, 64'h0001_FFFF_8000_0002, "R3");
    step(0, 1, 1, 2'd1, 2'd0, 64'h0000_0001_0000_1234, 64'h0001_0002_FFFF_1235, "R3");
    // R2: hold with valid low
    step(0, 0, 0, 2'd0, 2'd2, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "R2");
    step(0, 0, 1, 2'd1, 2'd1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, "R2");
    // R4: signed byte clamp, neighbour lanes in range or at edge
    step(0, 1, 0, 2'd0, 2'd1, 64'h7F80_7F80_0180_7F7F, 64'h0180_00FF_7F80_FF01, "R4");
    step(0, 1, 1, 2'd0, 2'd1, 64'h807F_8000_7F01_FF80, 64'h01FF_7F80_FF02_7F01, "R4");
    // R5: signed word clamp
    step(0, 1, 0, 2'd1, 2'd1, 64'h7FFF_8000_7FFF_00FF, 64'h0001_FFFF_8000_0001, "R5");
    step(0, 1, 1, 2'd1, 2'd1, 64'h8000_7FFF_0000_8001, 64'h0001_FFFF_8000_0001, "R5");
    // R6: unsigned byte clamp
    step(0, 1, 0, 2'd0, 2'd2, 64'hFF01_80FE_0000_FF7F, 64'h01FF_8001_0000_0081, "R6");
    step(0, 1, 1, 2'd0, 2'd2, 64'h0001_80FE_0000_FF00, 64'h0102_7FFF_0001_FE01, "R6");
    // R7: unsigned word clamp
    step(0, 1, 0, 2'd1, 2'd2, 64'hFFFF_8000_00FF_FFFE, 64'h0001_8000_FF00_0001, "R7");
    step(0, 1, 1, 2'd1, 2'd2, 64'h0000_8000_0100_0001, 64'h0001_7FFF_0101_0002, "R7");
    // R8: 32-bit lanes wrap in every mode
    step(0, 1, 0, 2'd2, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R8");
    step(0, 1, 1, 2'd2, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, "R8");
    // R9: spare codes
    step(0, 1, 0, 2'd3, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R9");
    step(0, 1, 0, 2'd0, 2'd3, 64'hFF7F_80FF_0000_0000, 64'h0101_8001_0000_0000, "R9");
    // R1: reset mid-stream
    step(1, 1, 0, 2'd0, 2'd0, 64'h1, 64'h1, "R1");
    // Mixed random traffic, covers R2..R9 together
    for (int n = 0; n < 600; n++) begin
      logic [63:0] ra;
      logic [63:0] rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (n % 5 == 0) rb = ~ra;
      step(0, ($urandom % 4) != 0, 1'($urandom), 2'($urandom), 2'($urandom),
           ra, rb, "R3-R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule